// File: doc/BRIEF.md
# Serial Peripheral Port with Shared Data Line

A byte-wide serial engine that runs as either the clock-generating controller or the clocked responder on a four-signal serial link. As controller it derives the serial clock from the module clock through a prescaler and a power-of-two rate step. It can drive the select line by itself for the length of each byte. It watches for a second controller pulling the select line low, which is a mode fault. Transfers are eight bits, most significant bit first. The clock idles low; the incoming bit is sampled on the rising edge and the next outgoing bit is shifted on the falling edge.

A single-line mode lets one data pin carry traffic in both directions. The controller uses its output-side pin and the responder uses its input-side pin; the other pin is released. A direction bit for the shared pin decides whether the shift register drives the pin and reads its own bits back, or stays off the pin and shifts in whatever the far end drives. Register-style inputs set the role, the line mode, the select behaviour, the clock divisor and the pin directions. The byte side is a load strobe with data, a received-byte output and a one-cycle done pulse.

Top module: `spi_port_core`

## Requirements
- R1: As controller, one serial clock period lasts (ctl_presc+1) * 2^(ctl_rate+1) module clock cycles.
- R2: As controller, a tx_load while idle starts an 8-bit transfer: sck_o idles low, mosi_o presents tx_data most significant bit first and holds each bit over a rising sck_o edge, and rx_done pulses high for exactly one cycle with rx_data holding the received byte.
- R3: With ctl_master=1, ctl_ssoe=1 and dir_ss=1, ss_oe is 1 and ss_o is low from the first serial clock edge of a transfer until rx_done, and high when idle.
- R4: With dir_ss=0 the select pin is an input (ss_oe=0). With dir_ss=1 and ctl_ssoe=0, ss_oe is 1 and ss_o stays high during a transfer.
- R5: As controller with dir_ss=0, ss_i held low raises mode_fault within 4 cycles. The fault drops the controller role (sck_oe=0, sck_o=0), aborts the transfer without rx_done, and stays set until ctl_en goes low.
- R6: While automatic select output is active (ctl_master=1, ctl_ssoe=1, dir_ss=1), a low ss_i never raises mode_fault.
- R7: With ctl_bidir=0, the controller drives mosi_o (mosi_oe=dir_mosi) and samples miso_i. The responder samples mosi_i and drives miso_o with miso_oe=dir_miso while ss_i is low, and miso_oe=0 while ss_i is high.
- R8: With ctl_bidir=1 as controller, miso_oe stays 0. With dir_mosi=1 the byte is driven on mosi_o and the same bits are shifted back in, so rx_data equals tx_data. With dir_mosi=0, mosi_oe=0 and the bits come from mosi_i.
- R9: With ctl_bidir=1 as responder, mosi_oe stays 0. With dir_miso=0, miso_oe=0 and the bits come from miso_i.
- R10: sck_oe is 1 only for an enabled controller. As responder both sck_oe and ss_oe are 0.
- R11: A mode fault with ctl_bidir=0 clears the effective MOSI direction (mosi_dir_eff=0). With ctl_bidir=1 it leaves mosi_dir_eff equal to dir_mosi.
- R12: The responder counts bits only while ss_i is low. Raising ss_i mid-byte discards the partial byte with no rx_done, and the next selected byte is received whole. tx_data is loaded while ss_i is high.
- R13: With ctl_en=0 all output enables are 0, sck_o stays 0 and tx_load has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Port enable; low also clears a mode fault |
| ctl_master | input | 1 | 1 = controller role, 0 = responder role |
| ctl_bidir | input | 1 | 1 = single shared data line |
| ctl_ssoe | input | 1 | Select output enable (automatic select) |
| ctl_presc | input | 3 | Clock prescaler field |
| ctl_rate | input | 3 | Clock power-of-two rate field |
| dir_mosi | input | 1 | Direction of MOSI-side pin (1 = output) |
| dir_miso | input | 1 | Direction of MISO-side pin (1 = output) |
| dir_ss | input | 1 | Direction of select pin (1 = output) |
| tx_load | input | 1 | Load strobe for tx_data |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last received byte |
| rx_done | output | 1 | One-cycle pulse at end of byte |
| sck_i | input | 1 | Serial clock from pad |
| sck_o | output | 1 | Serial clock to pad |
| sck_oe | output | 1 | Serial clock output enable |
| ss_i | input | 1 | Select from pad |
| ss_o | output | 1 | Select to pad |
| ss_oe | output | 1 | Select output enable |
| mosi_i | input | 1 | MOSI-side pad input |
| mosi_o | output | 1 | MOSI-side pad output |
| mosi_oe | output | 1 | MOSI-side output enable |
| miso_i | input | 1 | MISO-side pad input |
| miso_o | output | 1 | MISO-side pad output |
| miso_oe | output | 1 | MISO-side output enable |
| mode_fault | output | 1 | Mode fault flag |
| mosi_dir_eff | output | 1 | MOSI-side direction after fault clearing |

## Verification
The assertions assume the configuration inputs are quasi-static: role, line mode, divisor and direction bits change only while no byte is in flight. They also assume that ss_i and sck_i, although synchronized inside, change no faster than a few module clocks. The bench changes configuration only between transfers. It holds every responder clock and data phase for six module cycles, and it pulls ss_i low on a controller only in the fault and suppression tests.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   // Data pin routing chosen by line mode and effective role
   typedef enum logic [1:0] {
      ROUTE_SPLIT_CTL  = 2'b00,
      ROUTE_SPLIT_RSP  = 2'b01,
      ROUTE_SHARED_CTL = 2'b10,
      ROUTE_SHARED_RSP = 2'b11
   } route_e;

   function automatic route_e pick_route(input logic shared, input logic ctl_role);
      return route_e'({shared, ~ctl_role});
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad_cfg
         $error("spi_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= {STAGES{RST_VAL}};
            else        r_q <= {r_q[STAGES-2:0], d};
         end
         assign q = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int PRESC_W = 3,
   parameter int RATE_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   input  logic [RATE_W-1:0]  rate,
   output logic               tick
);
   localparam int HALF_W = PRESC_W + (1 << RATE_W);

   generate
      if (PRESC_W < 1 || RATE_W < 1 || HALF_W > 31) begin : g_bad_cfg
         $error("spi_baud_gen: divisor field widths out of range");
      end
   endgenerate

   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] cnt_q;

   // half of one serial clock period, in module clocks
   assign half = (HALF_W'(presc) + HALF_W'(1)) << rate;
   assign tick = run && (cnt_q == half - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + HALF_W'(1);
   end

   // R1
   half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && $stable(presc) && $stable(rate) |-> cnt_q < half);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ctl_role,
   input  logic              abort,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tick,
   input  logic              rsp_sel,
   input  logic              rsp_rise,
   input  logic              rsp_fall,
   input  logic              in_bit,
   output logic              busy,
   output logic              sck_gen,
   output logic              out_bit,
   output logic [DATA_W-1:0] rx_data,
   output logic              done
);
   localparam int            CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_cfg
         $error("spi_shift_engine: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              samp_q;
   logic              busy_q;
   logic              sck_q;
   logic              done_q;
   logic [DATA_W-1:0] rx_q;
   logic              do_sample;
   logic              do_shift;

   // edge events for both roles
   assign do_sample = ctl_role ? (busy_q && tick && !sck_q)  : (rsp_sel && rsp_rise);
   assign do_shift  = ctl_role ? (busy_q && tick &&  sck_q)  : (rsp_sel && rsp_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         samp_q  <= 1'b0;
         busy_q  <= 1'b0;
         sck_q   <= 1'b0;
         done_q  <= 1'b0;
         rx_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!en || abort) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cnt_q  <= '0;
         end else begin
            if (ctl_role) begin
               if (!busy_q && load) begin
                  shreg_q <= load_data;
                  busy_q  <= 1'b1;
                  sck_q   <= 1'b0;
                  cnt_q   <= '0;
               end else if (busy_q && tick) begin
                  sck_q <= ~sck_q;
               end
            end else begin
               busy_q <= 1'b0;
               sck_q  <= 1'b0;
               if (!rsp_sel) begin
                  cnt_q <= '0;
                  if (load) shreg_q <= load_data;
               end
            end

            if (do_sample) samp_q <= in_bit;

            if (do_shift) begin
               shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
               if (cnt_q == LAST) begin
                  cnt_q  <= '0;
                  done_q <= 1'b1;
                  rx_q   <= {shreg_q[DATA_W-2:0], samp_q};
                  if (ctl_role) busy_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign sck_gen = sck_q;
   assign out_bit = shreg_q[DATA_W-1];
   assign rx_data = rx_q;
   assign done    = done_q;

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   ctl_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_role && done |-> !busy && !sck_gen);
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
   import spi_port_pkg::*;
(
   input  logic   en,
   input  route_e route,
   input  logic   dir_mosi_eff,
   input  logic   dir_miso,
   input  logic   rsp_sel,
   input  logic   out_bit,
   input  logic   mosi_i,
   input  logic   miso_i,
   output logic   mosi_o,
   output logic   mosi_oe,
   output logic   miso_o,
   output logic   miso_oe,
   output logic   in_bit
);
   always_comb begin
      mosi_o  = out_bit;
      miso_o  = out_bit;
      mosi_oe = 1'b0;
      miso_oe = 1'b0;
      in_bit  = 1'b0;
      unique case (route)
         ROUTE_SPLIT_CTL: begin
            mosi_oe = en && dir_mosi_eff;
            in_bit  = miso_i;
         end
         ROUTE_SPLIT_RSP: begin
            miso_oe = en && dir_miso && rsp_sel;
            in_bit  = mosi_i;
         end
         ROUTE_SHARED_CTL: begin
            mosi_oe = en && dir_mosi_eff;
            in_bit  = dir_mosi_eff ? out_bit : mosi_i;
         end
         ROUTE_SHARED_RSP: begin
            miso_oe = en && dir_miso && rsp_sel;
            in_bit  = dir_miso ? out_bit : miso_i;
         end
         default: begin
            in_bit = 1'b0;
         end
      endcase
   end

   // R8 R9
   always_comb begin
      shared_single_pin_chk: assert (!(route[1] && mosi_oe && miso_oe));
   end
endmodule

// File: rtl/spi_port_core.sv
module spi_port_core
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PRESC_W     = 3,
   parameter int RATE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_en,
   input  logic              ctl_master,
   input  logic              ctl_bidir,
   input  logic              ctl_ssoe,
   input  logic [PRESC_W-1:0] ctl_presc,
   input  logic [RATE_W-1:0] ctl_rate,
   input  logic              dir_mosi,
   input  logic              dir_miso,
   input  logic              dir_ss,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_data,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              ss_i,
   output logic              ss_o,
   output logic              ss_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   output logic              mode_fault,
   output logic              mosi_dir_eff
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_cfg
         $error("spi_port_core: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic   ss_s, sck_s, sck_s_d;
   logic   fault_q, dir_clr_q;
   logic   ctl_role, auto_ss, fault_set;
   logic   tick, busy, sck_gen, out_bit, in_bit;
   logic   rsp_sel, rsp_rise, rsp_fall;
   route_e route;

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
      .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_s));

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_s_d <= 1'b0;
      else        sck_s_d <= sck_s;
   end

   assign rsp_sel  = ~ss_s;
   assign rsp_rise = sck_s & ~sck_s_d;
   assign rsp_fall = ~sck_s & sck_s_d;

   // role and select/fault control
   assign ctl_role  = ctl_master & ~fault_q;
   assign auto_ss   = ctl_en & ctl_role & ctl_ssoe & dir_ss;
   assign fault_set = ctl_en & ctl_role & ~dir_ss & ~ss_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q   <= 1'b0;
         dir_clr_q <= 1'b0;
      end else if (!ctl_en) begin
         fault_q   <= 1'b0;
         dir_clr_q <= 1'b0;
      end else if (fault_set) begin
         fault_q   <= 1'b1;
         dir_clr_q <= ~ctl_bidir;
      end
   end

   assign mode_fault   = fault_q;
   assign mosi_dir_eff = dir_mosi & ~dir_clr_q;
   assign route        = pick_route(ctl_bidir, ctl_role);

   spi_baud_gen #(.PRESC_W(PRESC_W), .RATE_W(RATE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .presc(ctl_presc), .rate(ctl_rate), .tick(tick));

   spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .en(ctl_en), .ctl_role(ctl_role),
      .abort(fault_set), .load(tx_load), .load_data(tx_data),
      .tick(tick), .rsp_sel(rsp_sel), .rsp_rise(rsp_rise), .rsp_fall(rsp_fall),
      .in_bit(in_bit), .busy(busy), .sck_gen(sck_gen), .out_bit(out_bit),
      .rx_data(rx_data), .done(rx_done));

   spi_pin_mux u_mux (
      .en(ctl_en), .route(route), .dir_mosi_eff(mosi_dir_eff), .dir_miso(dir_miso),
      .rsp_sel(rsp_sel), .out_bit(out_bit), .mosi_i(mosi_i), .miso_i(miso_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_o(miso_o), .miso_oe(miso_oe),
      .in_bit(in_bit));

   assign sck_o  = sck_gen;
   assign sck_oe = ctl_en & ctl_role;
   assign ss_oe  = ctl_en & ctl_role & dir_ss;
   assign ss_o   = ctl_ssoe ? ~busy : 1'b1;

   // R3
   ss_low_with_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_ss && sck_o |-> !ss_o && ss_oe);

   // R6
   no_fault_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_ss |=> !$rose(mode_fault));

   // R5
   fault_drops_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |-> !sck_oe && !rx_done);

   // R10
   rsp_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_role |-> !sck_oe && !ss_oe);
endmodule

// File: tb/spi_port_core_tb.sv
module spi_port_core_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       ctl_en = 0, ctl_master = 0, ctl_bidir = 0, ctl_ssoe = 0;
   logic [2:0] ctl_presc = 0, ctl_rate = 0;
   logic       dir_mosi = 0, dir_miso = 0, dir_ss = 0;
   logic       tx_load = 0;
   logic [7:0] tx_data = 0;
   logic [7:0] rx_data;
   logic       rx_done;
   logic       sck_i = 0, sck_o, sck_oe, ss_i = 1, ss_o, ss_oe;
   logic       mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
   logic       mode_fault, mosi_dir_eff;

   // 0 loopback mosi->miso, 1 const 0, 2 const 1, 3 manual
   logic [1:0] src = 2'd1;
   logic       man_mosi = 0, man_miso = 0;

   always_comb begin
      case (src)
         2'd0:    begin miso_i = mosi_o; mosi_i = 1'b0; end
         2'd1:    begin miso_i = 1'b0;   mosi_i = 1'b0; end
         2'd2:    begin miso_i = 1'b1;   mosi_i = 1'b1; end
         default: begin miso_i = man_miso; mosi_i = man_mosi; end
      endcase
   end

   spi_port_core dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_master(ctl_master),
      .ctl_bidir(ctl_bidir), .ctl_ssoe(ctl_ssoe), .ctl_presc(ctl_presc),
      .ctl_rate(ctl_rate), .dir_mosi(dir_mosi), .dir_miso(dir_miso), .dir_ss(dir_ss),
      .tx_load(tx_load), .tx_data(tx_data), .rx_data(rx_data), .rx_done(rx_done),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_i(ss_i), .ss_o(ss_o),
      .ss_oe(ss_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .mode_fault(mode_fault), .mosi_dir_eff(mosi_dir_eff));

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   logic [7:0] last_rx = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (rx_done) begin
            done_cnt++;
            last_rx = rx_data;
         end
      end
   endtask

   // bidir, dmosi, presc[3], rate[3], src[2], tx[8], exp[8]
   localparam int NV = 6;
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 1'b1, 3'd0, 3'd0, 2'd0, 8'hA5, 8'hA5},
      {1'b0, 1'b1, 3'd2, 3'd1, 2'd2, 8'h3C, 8'hFF},
      {1'b0, 1'b1, 3'd1, 3'd2, 2'd1, 8'hC3, 8'h00},
      {1'b1, 1'b1, 3'd0, 3'd1, 2'd1, 8'h96, 8'h96},
      {1'b1, 1'b0, 3'd0, 3'd0, 2'd2, 8'h5A, 8'hFF},
      {1'b0, 1'b1, 3'd7, 3'd2, 2'd0, 8'h81, 8'h81}
   };

   task automatic run_ctl(input logic [25:0] v, input string tag);
      int rises = 0, t1 = 0, t2 = 0, cyc = 0, exp_per;
      bit ss_hi = 0, miso_drv = 0, mosi_drv = 0, got = 0, prev = 0;
      logic [7:0] cap = 0;
      ctl_bidir = v[25]; dir_mosi = v[24]; ctl_presc = v[23:21]; ctl_rate = v[20:18];
      src = v[17:16]; tx_data = v[15:8];
      exp_per = (int'(v[23:21]) + 1) << (int'(v[20:18]) + 1);
      step(2);
      tx_load = 1; step(1); tx_load = 0;
      while (cyc < 4000 && !got) begin
         step(1); cyc++;
         if (rx_done) got = 1;
         else begin
            if (sck_o && !prev) begin
               rises++;
               if (rises == 1) t1 = cyc;
               if (rises == 2) t2 = cyc;
               cap = {cap[6:0], mosi_o};
            end
            if (rises > 0 && ss_o) ss_hi = 1;
            if (miso_oe) miso_drv = 1;
            if (mosi_oe) mosi_drv = 1;
            prev = sck_o;
         end
      end
      chk(got, {tag, " R2 done"}, got, 1);
      chk(last_rx == v[7:0], {tag, " R2 R7 R8 rx"}, last_rx, v[7:0]);
      chk(t2 - t1 == exp_per, {tag, " R1 period"}, t2 - t1, exp_per);
      chk(!ss_hi, {tag, " R3 ss low in transfer"}, ss_hi, 0);
      if (v[24]) chk(cap == v[15:8], {tag, " R2 mosi bits"}, cap, v[15:8]);
      else       chk(!mosi_drv, {tag, " R8 mosi released"}, mosi_drv, 1'b0);
      if (v[25]) chk(!miso_drv, {tag, " R8 miso released"}, miso_drv, 0);
      step(2);
      chk(ss_o == 1'b1, {tag, " R3 ss high idle"}, ss_o, 1);
      chk(!sck_o, {tag, " R2 sck idle low"}, sck_o, 0);
   endtask

   task automatic rsp_byte(input logic [7:0] b, input bit on_miso, output logic [7:0] seen);
      seen = 0;
      for (int k = 7; k >= 0; k--) begin
         if (on_miso) man_miso = b[k]; else man_mosi = b[k];
         step(6);
         seen = {seen[6:0], miso_o};
         sck_i = 1; step(6);
         sck_i = 0; step(6);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] seen;
      int d0;
      step(3);
      rst_n = 1;
      step(2);
      chk(!rx_done && !sck_oe && !mosi_oe && !miso_oe && !ss_oe && !mode_fault && !sck_o,
          "R13 reset state", {rx_done, sck_oe, mosi_oe, miso_oe, ss_oe, mode_fault}, 0);

      // R13 disabled port ignores load
      ctl_master = 1; dir_mosi = 1; dir_ss = 1; ctl_ssoe = 1;
      tx_load = 1; step(1); tx_load = 0; step(50);
      chk(done_cnt == 0 && !sck_o && !sck_oe && !mosi_oe && !ss_oe, "R13 disabled",
          {done_cnt[3:0], sck_o, sck_oe, mosi_oe, ss_oe}, 0);

      // controller vector table with automatic select
      ctl_en = 1; step(2);
      chk(sck_oe && ss_oe, "R10 R3 controller drives sck ss", {sck_oe, ss_oe}, 3);
      for (int i = 0; i < NV; i++) run_ctl(VEC[i], $sformatf("vec%0d", i));

      // R4 select as plain output, then as input
      ctl_bidir = 0; ctl_ssoe = 0; dir_ss = 1; src = 2'd0; ctl_presc = 0; ctl_rate = 1;
      step(2); tx_load = 1; step(1); tx_load = 0;
      begin
         bit low = 0;
         for (int k = 0; k < 60; k++) begin step(1); if (!ss_o) low = 1; end
         chk(!low && ss_oe, "R4 ss stays high without ssoe", {low, ss_oe}, 1);
      end
      dir_ss = 0; ctl_ssoe = 1; step(2);
      chk(!ss_oe, "R4 ss input when dir_ss=0", ss_oe, 0);

      // responder, split lines
      ctl_master = 0; ctl_bidir = 0; dir_miso = 1; src = 2'd3; ss_i = 1;
      tx_data = 8'h3C; tx_load = 1; step(1); tx_load = 0; step(4);
      chk(!sck_oe && !ss_oe, "R10 responder releases sck ss", {sck_oe, ss_oe}, 0);
      chk(!miso_oe, "R7 miso off while deselected", miso_oe, 0);
      ss_i = 0; step(6);
      chk(miso_oe && !mosi_oe, "R7 miso driven when selected", {miso_oe, mosi_oe}, 2);
      d0 = done_cnt;
      rsp_byte(8'hA5, 0, seen);
      step(4);
      chk(done_cnt == d0 + 1 && last_rx == 8'hA5, "R7 responder rx", last_rx, 8'hA5);
      chk(seen == 8'h3C, "R7 responder tx bits", seen, 8'h3C);
      ss_i = 1; step(6);

      // R12 partial byte discarded by select high
      ss_i = 0; step(6);
      d0 = done_cnt;
      for (int k = 0; k < 3; k++) begin
         man_mosi = 1'b1; step(6); sck_i = 1; step(6); sck_i = 0; step(6);
      end
      ss_i = 1; step(6);
      chk(done_cnt == d0, "R12 partial no done", done_cnt - d0, 0);
      ss_i = 0; step(6);
      rsp_byte(8'h0F, 0, seen);
      step(4);
      chk(done_cnt == d0 + 1 && last_rx == 8'h0F, "R12 whole byte after reselect", last_rx, 8'h0F);
      ss_i = 1; step(6);

      // R9 responder shared line as input
      ctl_bidir = 1; dir_miso = 0; step(2);
      ss_i = 0; step(6);
      rsp_byte(8'h6B, 1, seen);
      step(4);
      chk(last_rx == 8'h6B, "R9 shared responder rx", last_rx, 8'h6B);
      chk(!miso_oe && !mosi_oe, "R9 shared responder no drive", {miso_oe, mosi_oe}, 0);
      ss_i = 1; step(6);

      // R5 R11 fault in split mode
      ctl_master = 1; ctl_bidir = 0; ctl_ssoe = 0; dir_ss = 0; dir_mosi = 1;
      ctl_presc = 7; ctl_rate = 3; src = 2'd1; step(2);
      d0 = done_cnt;
      tx_load = 1; step(1); tx_load = 0; step(20);
      ss_i = 0; step(6);
      chk(mode_fault, "R5 fault raised", mode_fault, 1);
      chk(!sck_oe && !sck_o, "R5 role dropped", {sck_oe, sck_o}, 0);
      chk(!mosi_dir_eff, "R11 split fault clears dir", mosi_dir_eff, 0);
      ss_i = 1; step(2000);
      chk(done_cnt == d0 && mode_fault, "R5 aborted and held", {done_cnt[3:0] - d0[3:0], mode_fault}, 1);
      ctl_en = 0; step(3);
      chk(!mode_fault, "R5 cleared by disable", mode_fault, 0);
      ctl_en = 1; step(2);

      // R11 fault in shared mode keeps dir
      ctl_bidir = 1; step(2);
      ss_i = 0; step(6);
      chk(mode_fault && mosi_dir_eff, "R11 shared fault keeps dir", {mode_fault, mosi_dir_eff}, 3);
      ss_i = 1; ctl_en = 0; step(3); ctl_en = 1; step(2);

      // R6 automatic select suppresses fault
      ctl_bidir = 0; ctl_ssoe = 1; dir_ss = 1; step(2);
      ss_i = 0; step(8);
      chk(!mode_fault && sck_oe, "R6 no fault with auto select", {mode_fault, sck_oe}, 1);
      ss_i = 1; step(4);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule